// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Interrupt

This block holds received UART characters between the bit-level receiver and the register bank. Each stored entry carries one data byte plus three status bits (framing error, parity error, line break). Characters arrive on one of two valid/ready streams. One comes from the external deserializer. The other comes from the internal loopback path, and only that one is taken while loopback is on. The register bank pops the oldest entry with a one-cycle read strobe. The block reports empty, full and can-accept flags. It also gives the interrupt logic one-cycle set and clear pulses for the raw receive interrupt.

When the FIFO-enable input is high the buffer holds `DEPTH` entries (16 by default). When it is low the buffer becomes a single holding register. Ring indices are masked with the effective depth minus one, so `DEPTH` must be a power of two. The interrupt is not a level comparison. It pulses only when a push makes the occupancy equal to the trigger level, and clears only when a read leaves the occupancy one below it. Changing the FIFO-enable input, or pulsing the flush input, empties the buffer.

Back-pressure rules: a beat transfers on a cycle where valid and ready are both high. Ready depends on the current occupancy, the loopback selection and any flush in the same cycle. A source may hold valid while ready is low, and the beat waits. The stream not selected by loopback sees ready low for as long as it stays unselected.

Top module: `rx_trigger_fifo`

## Requirements
- R1: After reset, empty is 1, full is 0, both interrupt pulses are 0, the latched status is 0 and the external stream's ready is 1 once the reset-time mode flush is over.
- R2: Entries are returned in push order with their data byte and flag bits intact (flags bit0 framing, bit1 parity, bit2 break), across index wrap-around.
- R3: With the FIFO enabled, full goes high once 16 entries are held; ready is then low and a further offered beat is not taken.
- R4: With the FIFO disabled the effective depth is 1: one push sets full and drops ready, and a read returns that entry and sets empty.
- R5: irq_set pulses for one cycle, in the cycle after a push whose resulting occupancy equals the trigger level (1).
- R6: irq_clr pulses for one cycle after a read that leaves the occupancy equal to trigger level minus one, which includes a read of an empty buffer; when a set and a clear coincide only irq_set is issued.
- R7: A read of an empty buffer leaves it empty and the occupancy unchanged.
- R8: A beat whose break flag (bit2) is set is stored with its data byte forced to zero.
- R9: With loopback on, only the loopback stream is accepted (external ready low, external input ignored); with loopback off, only the external stream is accepted.
- R10: A flush pulse, or any change of the FIFO-enable input, empties the buffer (empty 1, full 0), and no beat is taken in that cycle.
- R11: On every read the popped entry's flag bits are latched into stat_flags; a stat_clr pulse without a read zeroes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_en | input | 1 | 1: depth DEPTH; 0: single holding register |
| loopback_en | input | 1 | Selects the loopback stream and ignores the external one |
| flush | input | 1 | Empties the buffer |
| ext_valid | input | 1 | External stream beat valid |
| ext_ready | output | 1 | External stream ready |
| ext_data | input | DW | External data byte |
| ext_flags | input | 3 | External flags: bit0 framing, bit1 parity, bit2 break |
| lb_valid | input | 1 | Loopback stream beat valid |
| lb_ready | output | 1 | Loopback stream ready |
| lb_data | input | DW | Loopback data byte |
| lb_flags | input | 3 | Loopback flags, same encoding |
| rd_req | input | 1 | Data read strobe, pops one entry |
| rd_data | output | DW | Data byte at the head (combinational) |
| rd_flags | output | 3 | Flags at the head (combinational) |
| stat_clr | input | 1 | Clears the latched status |
| stat_flags | output | 3 | Flags of the last popped entry |
| empty | output | 1 | Buffer empty |
| full | output | 1 | Occupancy equals effective depth |
| can_accept | output | 1 | Room for a beat and no flush this cycle |
| irq_set | output | 1 | Raw receive interrupt set pulse |
| irq_clr | output | 1 | Raw receive interrupt clear pulse |

## Verification
The head entry on rd_data and rd_flags is combinational, so the bench samples it in the same cycle it raises rd_req, before the clock edge that pops the entry. The empty and full flags, the two interrupt pulses and stat_flags are registered. They are due in the cycle after the edge that takes a beat, performs a read or flushes. The bench drives every stimulus on a falling edge and checks these results at the next falling edge after the active edge. A pulse that is due is therefore seen inside its single high cycle, and an expected absence is checked in that same window.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int FLAG_W = 3;
  localparam int FLG_FRAME = 0;
  localparam int FLG_PARITY = 1;
  localparam int FLG_BREAK = 2;

  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rxf_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int EW = 11,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [EW-1:0] wdata,
  input  logic [PW-1:0] ridx,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (widx == PW'(i))) slot[i] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/rxf_srcsel.sv
module rxf_srcsel #(
  parameter int DW = 8,
  localparam int EW = DW + rxf_pkg::FLAG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      loopback_en,
  input  logic                      can_accept,
  input  logic                      ext_valid,
  input  logic [DW-1:0]             ext_data,
  input  logic [rxf_pkg::FLAG_W-1:0] ext_flags,
  output logic                      ext_ready,
  input  logic                      lb_valid,
  input  logic [DW-1:0]             lb_data,
  input  logic [rxf_pkg::FLAG_W-1:0] lb_flags,
  output logic                      lb_ready,
  output logic                      push,
  output logic [EW-1:0]             wentry
);
  import rxf_pkg::*;

  logic [DW-1:0]     sel_data;
  rxf_flags_t        sel_flags;

  assign ext_ready = can_accept && !loopback_en;
  assign lb_ready  = can_accept && loopback_en;
  assign push      = (ext_valid && ext_ready) || (lb_valid && lb_ready);

  always_comb begin
    if (loopback_en) begin
      sel_data  = lb_data;
      sel_flags = rxf_flags_t'(lb_flags);
    end else begin
      sel_data  = ext_data;
      sel_flags = rxf_flags_t'(ext_flags);
    end
    if (sel_flags.brk) sel_data = '0;
  end

  assign wentry = {sel_flags, sel_data};

  p_one_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_ready && lb_ready));
  p_no_ext_in_loop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_en |-> !ext_ready);
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int DEPTH = 16,
  parameter int TRIG = 1,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          flush,
  input  logic          push,
  input  logic          rd_req,
  output logic          can_accept,
  output logic [PW-1:0] widx,
  output logic [PW-1:0] ridx,
  output logic          empty,
  output logic          full,
  output logic          irq_set,
  output logic          irq_clr
);
  logic [CW-1:0] count_q, count_n, after_pop, eff_depth;
  logic [PW-1:0] rptr_q, rptr_n, mask;
  logic          mode_q, flush_int, pop_dec, set_n, clr_n;

  assign eff_depth = fifo_en ? CW'(DEPTH) : CW'(1);
  assign mask      = fifo_en ? PW'(DEPTH - 1) : '0;
  assign flush_int = flush || (fifo_en != mode_q);
  assign can_accept = (count_q < eff_depth) && !flush_int;

  assign pop_dec   = rd_req && (count_q != '0);
  assign after_pop = count_q - CW'(pop_dec);
  assign widx      = (rptr_q + PW'(count_q)) & mask;
  assign ridx      = rptr_q;

  always_comb begin
    if (flush_int) begin
      count_n = '0;
      rptr_n  = '0;
    end else begin
      count_n = after_pop + CW'(push);
      rptr_n  = pop_dec ? ((rptr_q + PW'(1)) & mask) : rptr_q;
    end
    set_n = push && !flush_int && ((after_pop + CW'(1)) == CW'(TRIG));
    clr_n = rd_req && !set_n && ((after_pop + CW'(1)) == CW'(TRIG));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rptr_q  <= '0;
      mode_q  <= 1'b0;
      empty   <= 1'b1;
      full    <= 1'b0;
      irq_set <= 1'b0;
      irq_clr <= 1'b0;
    end else begin
      count_q <= count_n;
      rptr_q  <= rptr_n;
      mode_q  <= fifo_en;
      empty   <= (count_n == '0);
      full    <= (count_n == eff_depth);
      irq_set <= set_n;
      irq_clr <= clr_n;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && (count_q >= eff_depth)));
  p_set_has_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> $past(push));
  p_empty_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty && !push && !flush_int) |=> empty);
  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_int |=> (empty && !full));
  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_set && irq_clr));
endmodule

// File: rtl/rx_trigger_fifo.sv
module rx_trigger_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  parameter int TRIG = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          loopback_en,
  input  logic          flush,
  input  logic          ext_valid,
  output logic          ext_ready,
  input  logic [DW-1:0] ext_data,
  input  logic [2:0]    ext_flags,
  input  logic          lb_valid,
  output logic          lb_ready,
  input  logic [DW-1:0] lb_data,
  input  logic [2:0]    lb_flags,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    rd_flags,
  input  logic          stat_clr,
  output logic [2:0]    stat_flags,
  output logic          empty,
  output logic          full,
  output logic          can_accept,
  output logic          irq_set,
  output logic          irq_clr
);
  import rxf_pkg::*;

  localparam int EW = DW + FLAG_W;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          push;
  logic [EW-1:0] wentry, head;
  logic [PW-1:0] widx, ridx;

  rxf_srcsel #(.DW(DW)) u_sel (
    .clk(clk), .rst_n(rst_n), .loopback_en(loopback_en), .can_accept(can_accept),
    .ext_valid(ext_valid), .ext_data(ext_data), .ext_flags(ext_flags), .ext_ready(ext_ready),
    .lb_valid(lb_valid), .lb_data(lb_data), .lb_flags(lb_flags), .lb_ready(lb_ready),
    .push(push), .wentry(wentry)
  );

  rxf_ctrl #(.DEPTH(DEPTH), .TRIG(TRIG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush), .push(push),
    .rd_req(rd_req), .can_accept(can_accept), .widx(widx), .ridx(ridx),
    .empty(empty), .full(full), .irq_set(irq_set), .irq_clr(irq_clr)
  );

  rxf_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk(clk), .we(push), .widx(widx), .wdata(wentry), .ridx(ridx), .rdata(head)
  );

  assign rd_data  = head[DW-1:0];
  assign rd_flags = head[EW-1:DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stat_flags <= '0;
    else if (rd_req)   stat_flags <= rd_flags;
    else if (stat_clr) stat_flags <= '0;
  end

  p_stat_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (stat_flags == $past(rd_flags)));
endmodule

// File: tb/sim_rx_trigger_fifo.sv
module sim_rx_trigger_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1, loopback_en = 1'b0, flush = 1'b0;
  logic ext_valid = 1'b0, lb_valid = 1'b0, rd_req = 1'b0, stat_clr = 1'b0;
  logic [7:0] ext_data = '0, lb_data = '0;
  logic [2:0] ext_flags = '0, lb_flags = '0;
  logic ext_ready, lb_ready, empty, full, can_accept, irq_set, irq_clr;
  logic [7:0] rd_data;
  logic [2:0] rd_flags, stat_flags;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] got_d;
  logic [2:0] got_f;
  logic got_rdy;

  always #4 clk = ~clk;

  rx_trigger_fifo u0 (.*);

  typedef struct packed {
    logic [1:0] op;     // 0 ext push, 2 read
    logic [7:0] d;
    logic [2:0] f;
    logic       chk_d;
    logic       e;
    logic       fu;
    logic       s;
    logic       c;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{2'd0, 8'hA5, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd0, 8'h3C, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 8'h77, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'hA5, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'h3C, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 8'h77, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd2, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd0, 8'h10, 3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd2, 8'h00, 3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic push_ext(input logic [7:0] d, input logic [2:0] f);
    ext_valid = 1'b1; ext_data = d; ext_flags = f;
    #1 got_rdy = ext_ready;
    tick();
    ext_valid = 1'b0;
  endtask

  task automatic push_lb(input logic [7:0] d, input logic [2:0] f);
    lb_valid = 1'b1; lb_data = d; lb_flags = f;
    #1 got_rdy = lb_ready;
    tick();
    lb_valid = 1'b0;
  endtask

  task automatic do_read();
    rd_req = 1'b1;
    #1 begin got_d = rd_data; got_f = rd_flags; end
    tick();
    rd_req = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 irq_set", irq_set, 0);
    chk("R1 irq_clr", irq_clr, 0);
    chk("R1 stat", stat_flags, 0);
    chk("R1 ext_ready", ext_ready, 1);

    // Table walk: R2 order, R5 set, R6 clear, R7 empty read, R8 break
    for (int i = 0; i < 9; i++) begin
      if (TBL[i].op == 2'd0) begin
        push_ext(TBL[i].d, TBL[i].f);
        chk("R2 push ready", got_rdy, 1);
      end else begin
        do_read();
        if (TBL[i].chk_d) begin
          chk("R2/R8 read data", got_d, TBL[i].d);
          chk("R2/R8 read flags", got_f, TBL[i].f);
        end
      end
      chk("R7 empty", empty, TBL[i].e);
      chk("R3 full", full, TBL[i].fu);
      chk("R5 irq_set", irq_set, TBL[i].s);
      chk("R6 irq_clr", irq_clr, TBL[i].c);
    end

    // R11 status latch and clear
    push_ext(8'h21, 3'd2);
    do_read();
    chk("R11 latched", stat_flags, 2);
    stat_clr = 1'b1; tick(); stat_clr = 1'b0;
    chk("R11 cleared", stat_flags, 0);

    // R3 fill to 16 across wrap, R2 drain order
    for (int i = 0; i < 16; i++) push_ext(8'(i * 7 + 1), 3'(i % 3));
    chk("R3 full at 16", full, 1);
    chk("R3 ready low", ext_ready, 0);
    push_ext(8'hEE, 3'd0);
    chk("R3 extra refused", got_rdy, 0);
    for (int i = 0; i < 16; i++) begin
      do_read();
      chk("R2 drain data", got_d, 8'(i * 7 + 1));
      chk("R2 drain flags", got_f, 3'(i % 3));
    end
    chk("R3 empty after drain", empty, 1);

    // R9 loopback selection
    loopback_en = 1'b1;
    #1 chk("R9 ext ignored", ext_ready, 0);
    push_ext(8'h44, 3'd0);
    chk("R9 ext not stored", empty, 1);
    push_lb(8'h5A, 3'd0);
    chk("R9 lb accepted", got_rdy, 1);
    do_read();
    chk("R9 lb data", got_d, 8'h5A);
    loopback_en = 1'b0;
    #1 chk("R9 lb blocked", lb_ready, 0);
    @(negedge clk);

    // R10 flush
    push_ext(8'h01, 3'd0);
    push_ext(8'h02, 3'd0);
    flush = 1'b1;
    #1 chk("R10 no accept in flush", can_accept, 0);
    tick(); flush = 1'b0;
    chk("R10 flush empty", empty, 1);
    chk("R10 flush full", full, 0);

    // R4 single-entry mode, entered through a mode-change flush (R10)
    push_ext(8'h0F, 3'd0);
    fifo_en = 1'b0;
    tick();
    chk("R10 mode change empties", empty, 1);
    push_ext(8'hC3, 3'd1);
    chk("R4 full at 1", full, 1);
    chk("R4 ready low", ext_ready, 0);
    chk("R5 set depth1", irq_set, 1);
    do_read();
    chk("R4 read data", got_d, 8'hC3);
    chk("R4 empty", empty, 1);
    chk("R6 clr depth1", irq_clr, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule